// File: doc/BRIEF.md
# Exact Product Renormalizer for Narrow Floating-Point Significands

This block forms the exact product of two narrow floating-point significands and hands it on in normalized form, ready for a wider-format datapath. Each operand arrives as a raw exponent field and a fraction field. When the exponent field is zero the operand is subnormal. The block multiplies the two full significands exactly into a 2p-bit product. Alongside the multiplier, it counts the leading zeros of each significand. It then shifts the product left by the sum of the two counts, plus at most one more position, so that bit 2p-1 holds a one.

The matching unbiased exponent is produced as a signed value wide enough for the wider format's range. Any product of two narrow values, subnormal or not, is a normal number in the format of twice the width, so the block needs no underflow or overflow path. A zero significand on either side raises a zero flag instead of being normalized. The narrow format is selected by a parameter: half (5-bit exponent, 10-bit fraction) or single (8-bit exponent, 23-bit fraction).

Results are registered, with a one-cycle valid pipeline and no stall.

Top module: `nfm_prod_renorm`

## Requirements
- R1: An operand with exponent field 0 is decoded with a hidden bit of 0 and an unbiased exponent of 1-bias. Any other field value gives a hidden bit of 1 and an exponent of field-bias. Here bias = 2^(EXP_W-1)-1. The all-ones field is treated as an ordinary finite value.
- R2: While reset is high, out_valid, out_zero, out_sig and out_exp are 0. out_valid rises exactly one clock after a cycle with in_valid high and is low after any cycle with in_valid low.
- R3: For nonzero operands, out_sig bit 2P-1 is 1, where P = FRAC_W+1. Also, out_sig × 2^(out_exp-(2P-1)) equals the exact product of the two operand magnitudes.
- R4: The normalizing left shift equals the sum of the two operand leading-zero counts, measured over P bits, plus 0 or 1. No product bit is lost.
- R5: If either operand significand is zero (exponent field 0 and fraction 0), out_zero is 1, out_sig is 0 and out_exp is 0. Otherwise out_zero is 0.
- R6: For nonzero operands, out_exp lies within [2·(1-bias-FRAC_W), 2·(bias+1)+1]. With single format this range is [-298, 257].
- R7: Parameter FMT = NFMT_HALF selects EXP_W = 5 and FRAC_W = 10. FMT = NFMT_SINGLE selects EXP_W = 8 and FRAC_W = 23. R1 to R6 hold in both cases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair present this cycle |
| a_exp | input | EXP_W | Exponent field of operand A |
| a_frac | input | FRAC_W | Fraction field of operand A |
| b_exp | input | EXP_W | Exponent field of operand B |
| b_frac | input | FRAC_W | Fraction field of operand B |
| out_valid | output | 1 | Registered result present |
| out_zero | output | 1 | Product is zero |
| out_sig | output | 2P | Normalized product significand, leading one at the top |
| out_exp | output | OEXP_W | Signed unbiased exponent of the product |

## Verification
The bench targets products of the smallest subnormals with each other. A shifter that is too narrow, or a wrong shift sum, would drop or misplace the only significant bit and give a wrong exponent near -298. It also runs products whose leading one lands one position short of the top, such as 1.0 times 1.0 or products of subnormals with small fractions. A design without the final one-bit correction would leave bit 2P-1 clear or be off by one in the exponent. Zero operands paired with large and subnormal partners check that the flag suppresses the shift and clears the outputs. All-ones exponent fields, and a half-format instance fed directly and with random vectors, expose decoding and parameter errors.

// File: rtl/nfm_pkg.sv
package nfm_pkg;

    typedef enum logic {
        NFMT_HALF   = 1'b0,
        NFMT_SINGLE = 1'b1
    } nfmt_e;

    typedef struct packed {
        logic valid;
        logic zero;
    } nfm_flags_t;

    function automatic int fmt_exp_w(nfmt_e f);
        return (f == NFMT_HALF) ? 5 : 8;
    endfunction

    function automatic int fmt_frac_w(nfmt_e f);
        return (f == NFMT_HALF) ? 10 : 23;
    endfunction

    function automatic int fmt_bias(nfmt_e f);
        return (1 << (fmt_exp_w(f) - 1)) - 1;
    endfunction

endpackage

// File: rtl/nfm_lzc.sv
module nfm_lzc #(
    parameter int W = 24,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count,
    output logic          all_zero
);

    logic found;

    always_comb begin
        count = CW'(W);
        found = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!found && vec[i]) begin
                count = CW'(W - 1 - i);
                found = 1'b1;
            end
        end
        all_zero = ~found;
    end

endmodule

// File: rtl/nfm_unpack.sv
module nfm_unpack #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int OEXP_W = 12,
    localparam int P     = FRAC_W + 1,
    localparam int LZ_W  = $clog2(P + 1)
) (
    input  logic [EXP_W-1:0]         exp_fld,
    input  logic [FRAC_W-1:0]        frac_fld,
    output logic [P-1:0]             mant,
    output logic signed [OEXP_W-1:0] exp_unb,
    output logic [LZ_W-1:0]          lz,
    output logic                     is_zero
);

    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam logic signed [OEXP_W-1:0] SUB_EXP = OEXP_W'(1 - BIAS);
    localparam logic signed [OEXP_W-1:0] BIAS_W  = OEXP_W'(BIAS);

    logic is_sub;

    assign is_sub  = (exp_fld == '0);
    assign mant    = {~is_sub, frac_fld};
    assign exp_unb = is_sub ? SUB_EXP : ($signed(OEXP_W'(exp_fld)) - BIAS_W);

    nfm_lzc #(.W(P)) lzc_i (
        .vec      (mant),
        .count    (lz),
        .all_zero (is_zero)
    );

endmodule

// File: rtl/nfm_renorm.sv
module nfm_renorm #(
    parameter int P     = 24,
    localparam int PW   = 2 * P,
    localparam int SH_W = $clog2(PW + 1)
) (
    input  logic [PW-1:0]   prod,
    input  logic [SH_W-1:0] shamt,
    output logic [PW-1:0]   norm,
    output logic            extra
);

    logic [PW-1:0] stg [SH_W+1];

    assign stg[0] = prod;

    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        assign stg[k+1] = shamt[k] ? (stg[k] << (1 << k)) : stg[k];
    end

    assign extra = ~stg[SH_W][PW-1];
    assign norm  = extra ? {stg[SH_W][PW-2:0], 1'b0} : stg[SH_W];

endmodule

// File: rtl/nfm_prod_renorm.sv
module nfm_prod_renorm
    import nfm_pkg::*;
#(
    parameter nfmt_e FMT    = NFMT_SINGLE,
    parameter int    OEXP_W = 12,
    localparam int EXP_W  = fmt_exp_w(FMT),
    localparam int FRAC_W = fmt_frac_w(FMT),
    localparam int P      = FRAC_W + 1,
    localparam int PW     = 2 * P
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [EXP_W-1:0]         a_exp,
    input  logic [FRAC_W-1:0]        a_frac,
    input  logic [EXP_W-1:0]         b_exp,
    input  logic [FRAC_W-1:0]        b_frac,
    output logic                     out_valid,
    output logic                     out_zero,
    output logic [PW-1:0]            out_sig,
    output logic signed [OEXP_W-1:0] out_exp
);

    localparam int LZ_W   = $clog2(P + 1);
    localparam int SH_W   = $clog2(PW + 1);
    localparam int BIAS   = fmt_bias(FMT);
    localparam int EMIN_P = 2 * (1 - BIAS - FRAC_W);
    localparam int EMAX_P = 2 * (BIAS + 1) + 1;

    logic [P-1:0]             mant_a, mant_b;
    logic signed [OEXP_W-1:0] exp_a, exp_b;
    logic [LZ_W-1:0]          lz_a, lz_b;
    logic                     zero_a, zero_b;
    logic [PW-1:0]            prod, norm;
    logic [SH_W-1:0]          shamt;
    logic                     extra;
    logic                     zero_n;
    logic signed [OEXP_W-1:0] exp_n;
    nfm_flags_t               flags_q;

    nfm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .OEXP_W(OEXP_W)) unpack_a_i (
        .exp_fld (a_exp), .frac_fld (a_frac),
        .mant (mant_a), .exp_unb (exp_a), .lz (lz_a), .is_zero (zero_a)
    );

    nfm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .OEXP_W(OEXP_W)) unpack_b_i (
        .exp_fld (b_exp), .frac_fld (b_frac),
        .mant (mant_b), .exp_unb (exp_b), .lz (lz_b), .is_zero (zero_b)
    );

    // Exact product; leading-zero counts run beside it.
    assign prod   = PW'(mant_a) * PW'(mant_b);
    assign zero_n = zero_a | zero_b;
    assign shamt  = zero_n ? '0 : (SH_W'(lz_a) + SH_W'(lz_b));

    nfm_renorm #(.P(P)) renorm_i (
        .prod (prod), .shamt (shamt), .norm (norm), .extra (extra)
    );

    assign exp_n = exp_a + exp_b
                 - $signed(OEXP_W'(shamt))
                 - $signed(OEXP_W'(extra))
                 + $signed(OEXP_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            out_sig <= '0;
            out_exp <= '0;
        end else begin
            flags_q.valid <= in_valid;
            if (in_valid) begin
                flags_q.zero <= zero_n;
                out_sig      <= zero_n ? '0 : norm;
                out_exp      <= zero_n ? '0 : exp_n;
            end
        end
    end

    assign out_valid = flags_q.valid;
    assign out_zero  = flags_q.zero;

    // R2: valid follows input one cycle later
    a_r2_valid_rise: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r2_valid_fall: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R3: leading one at the top for a nonzero product
    a_r3_lead_one: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_zero) |-> out_sig[PW-1]);
    // R4: shifting back recovers the raw product, no bit lost
    a_r4_no_lost_bits: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !zero_n) |-> ((norm >> (int'(shamt) + int'(extra))) == prod));
    // R5: zero flag clears the outputs
    a_r5_zero_clear: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_zero) |-> (out_sig == '0 && out_exp == '0));
    // R6: exponent stays inside the product range
    a_r6_exp_range: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_zero) |-> (int'(out_exp) >= EMIN_P && int'(out_exp) <= EMAX_P));

endmodule

// File: tb/nfm_prod_renorm_tb_top.sv
module nfm_prod_renorm_tb_top;
    import nfm_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 100000;

    typedef struct {
        bit      zero;
        longint  sig;
        int      ex;
        int      emin;
        int      emax;
        string   tag;
    } exp_item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    // single-format instance
    logic        s_in_valid = 1'b0;
    logic [7:0]  s_a_exp = '0, s_b_exp = '0;
    logic [22:0] s_a_frac = '0, s_b_frac = '0;
    logic        s_out_valid, s_out_zero;
    logic [47:0] s_out_sig;
    logic signed [11:0] s_out_exp;

    // half-format instance
    logic        h_in_valid = 1'b0;
    logic [4:0]  h_a_exp = '0, h_b_exp = '0;
    logic [9:0]  h_a_frac = '0, h_b_frac = '0;
    logic        h_out_valid, h_out_zero;
    logic [21:0] h_out_sig;
    logic signed [11:0] h_out_exp;

    nfm_prod_renorm #(.FMT(NFMT_SINGLE), .OEXP_W(12)) dut_i (
        .clk (clk), .rst (rst), .in_valid (s_in_valid),
        .a_exp (s_a_exp), .a_frac (s_a_frac), .b_exp (s_b_exp), .b_frac (s_b_frac),
        .out_valid (s_out_valid), .out_zero (s_out_zero),
        .out_sig (s_out_sig), .out_exp (s_out_exp)
    );

    nfm_prod_renorm #(.FMT(NFMT_HALF), .OEXP_W(12)) dut_h_i (
        .clk (clk), .rst (rst), .in_valid (h_in_valid),
        .a_exp (h_a_exp), .a_frac (h_a_frac), .b_exp (h_b_exp), .b_frac (h_b_frac),
        .out_valid (h_out_valid), .out_zero (h_out_zero),
        .out_sig (h_out_sig), .out_exp (h_out_exp)
    );

    exp_item_t q_s[$];
    exp_item_t q_h[$];
    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    int cyc      = 0;
    logic [31:0] lfsr = 32'h1234_5678;

    task automatic check(bit ok, string tag, string what, longint got, longint expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s got %0d expected %0d", tag, what, got, expv);
        end
    endtask

    // Integer reference: decode, multiply, locate msb, place it at the top.
    function automatic exp_item_t ref_model(int ew, int fw, int ae, int af, int be, int bf, string tag);
        exp_item_t it;
        int bias = (1 << (ew - 1)) - 1;
        longint ma = (ae != 0 ? (longint'(1) << fw) : 0) + af;
        longint mb = (be != 0 ? (longint'(1) << fw) : 0) + bf;
        int ea = (ae == 0) ? 1 - bias : ae - bias;
        int eb = (be == 0) ? 1 - bias : be - bias;
        longint prod = ma * mb;
        int msb = 0;
        it.tag  = tag;
        it.emin = 2 * (1 - bias - fw);
        it.emax = 2 * (bias + 1) + 1;
        if (prod == 0) begin
            it.zero = 1'b1; it.sig = 0; it.ex = 0;
        end else begin
            for (int i = 0; i < 64; i++) if (prod[i]) msb = i;
            it.zero = 1'b0;
            it.sig  = prod << (2 * (fw + 1) - 1 - msb);
            it.ex   = ea + eb - 2 * fw + msb;
        end
        return it;
    endfunction

    task automatic drive(bit half, int ae, int af, int be, int bf, string tag);
        @(negedge clk);
        if (half) begin
            s_in_valid = 1'b0;
            h_in_valid = 1'b1;
            h_a_exp = 5'(ae); h_a_frac = 10'(af); h_b_exp = 5'(be); h_b_frac = 10'(bf);
            q_h.push_back(ref_model(5, 10, ae & 31, af & 1023, be & 31, bf & 1023, tag));
        end else begin
            h_in_valid = 1'b0;
            s_in_valid = 1'b1;
            s_a_exp = 8'(ae); s_a_frac = 23'(af); s_b_exp = 8'(be); s_b_frac = 23'(bf);
            q_s.push_back(ref_model(8, 23, ae & 255, af & 32'h7F_FFFF,
                                    be & 255, bf & 32'h7F_FFFF, tag));
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            s_in_valid = 1'b0;
            h_in_valid = 1'b0;
        end
    endtask

    function automatic logic [31:0] nxt(logic [31:0] v);
        logic [31:0] x = v;
        x ^= x << 13; x ^= x >> 17; x ^= x << 5;
        return x;
    endfunction

    task automatic compare(exp_item_t it, bit zero, longint sig, int ex);
        check(zero == it.zero, it.tag, "zero R5", longint'(zero), longint'(it.zero));
        check(sig == it.sig, it.tag, "sig R3", sig, it.sig);
        check(ex == it.ex, it.tag, "exp R3", longint'(ex), longint'(it.ex));
        if (!it.zero)
            check(ex >= it.emin && ex <= it.emax, "R6", "exp range", longint'(ex), longint'(it.ex));
    endtask

    // Monitors
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (s_out_valid) begin
                if (q_s.size() == 0) check(1'b0, "R2", "single unexpected valid", 1, 0);
                else compare(q_s.pop_front(), s_out_zero, longint'(s_out_sig), int'(s_out_exp));
            end
            if (h_out_valid) begin
                if (q_h.size() == 0) check(1'b0, "R2", "half unexpected valid", 1, 0);
                else compare(q_h.pop_front(), h_out_zero, longint'(h_out_sig), int'(h_out_exp));
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc >= WDOG_LIMIT && !done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog got %0d expected below %0d", cyc, WDOG_LIMIT);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset state
        check(s_out_valid == 1'b0 && h_out_valid == 1'b0, "R2", "valid in reset", longint'(s_out_valid), 0);
        check(s_out_sig == '0 && s_out_exp == '0 && s_out_zero == 1'b0, "R2", "single data in reset",
              longint'(s_out_sig), 0);
        rst = 1'b0;
        @(negedge clk);
        check(s_out_valid == 1'b0, "R2", "valid after reset", longint'(s_out_valid), 0);

        // single format
        drive(0, 127, 0, 127, 0, "R3 one*one");                       // leading one one short
        drive(0, 127, 32'h40_0000, 127, 32'h40_0000, "R3 1.5*1.5");  // top bit set directly
        drive(0, 0, 1, 0, 1, "R4 min sub squared");                   // exp -298
        drive(0, 0, 32'h7F_FFFF, 0, 32'h7F_FFFF, "R4 max sub squared");
        drive(0, 0, 3, 130, 32'h12_3456, "R4 sub*normal");
        drive(0, 254, 32'h7F_FFFF, 254, 32'h7F_FFFF, "R6 max normal squared");
        drive(0, 255, 32'h7F_FFFF, 255, 32'h7F_FFFF, "R1 all-ones field");
        drive(0, 255, 0, 0, 1, "R1 all-ones times min sub");
        drive(0, 0, 0, 200, 32'h55_5555, "R5 zero a");
        drive(0, 254, 32'h7F_FFFF, 0, 0, "R5 zero b");
        drive(0, 0, 0, 0, 0, "R5 both zero");
        drive(0, 0, 32'h40_0000, 1, 0, "R1 sub vs min normal");
        idle(2);
        check(s_out_valid == 1'b0, "R2", "valid after idle", longint'(s_out_valid), 0);

        // half format
        drive(1, 15, 0, 15, 0, "R7 half one*one");
        drive(1, 0, 1, 0, 1, "R7 half min sub squared");
        drive(1, 30, 1023, 30, 1023, "R7 half max normal squared");
        drive(1, 31, 512, 0, 7, "R7 half all-ones times sub");
        drive(1, 0, 0, 17, 100, "R7 half zero");
        idle(1);

        // random, mixing formats and gaps, biased toward subnormals
        for (int i = 0; i < 600; i++) begin
            int ae, be;
            lfsr = nxt(lfsr);
            ae = (lfsr[1:0] == 2'b00) ? 0 : int'(lfsr[31:24]);
            lfsr = nxt(lfsr);
            be = (lfsr[1:0] == 2'b01) ? 0 : int'(lfsr[31:24]);
            lfsr = nxt(lfsr);
            if (lfsr[3]) drive(1, ae, int'(lfsr[27:18]), be, int'(lfsr[17:8] >> lfsr[7:4]), "R7 half random");
            else         drive(0, ae, int'(lfsr[31:9]), be, int'(lfsr[22:0] >> lfsr[8:4]), "R3 random");
            if (lfsr[2:0] == 3'b111) idle(1);
        end
        idle(3);
        check(q_s.size() == 0, "R2", "single results pending", longint'(q_s.size()), 0);
        check(q_h.size() == 0, "R2", "half results pending", longint'(q_h.size()), 0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule